// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Transmit Queue

This block turns bytes written by a processor into characters on one asynchronous serial line. Bit timing comes from an external enable that pulses once per sixteenth of a bit. Written bytes wait in a queue of up to 16 entries. Each character is sent as a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period of one, one and a half or two bits. When nothing is waiting, the line idles high.

A mode input selects between the full queue and a single holding register. In the single-register mode, one byte waits while another is being shifted out. Changing the mode empties the queue. A break input drives the line low. While break is set, no new character starts and queued bytes are kept. A loopback input moves the serial stream to a separate diagnostic output and parks the line high. Two flags show whether the queue is empty and whether the shifter is idle.

Top module: `serial_tx_queue`

## Requirements
- R1: After reset, serOut is 1, fifoEmpty is 1 and shifterEmpty is 1.
- R2: A character starts with a 0 bit, followed by 5 + charLen data bits sent LSB first (charLen 0 to 3). Each bit lasts 16 tick pulses.
- R3: When parityEn is 1, one parity bit follows the data. With parityOdd 0 the data bits plus the parity bit hold an even number of ones; with parityOdd 1 they hold an odd number. When parityEn is 0, no parity bit is sent.
- R4: The stop level is 1. It lasts 16 ticks when stopLong is 0. When stopLong is 1, it lasts 24 ticks with charLen 0 and 32 ticks with any other charLen. A waiting byte starts on the tick that ends the stop period, so back-to-back starts are 16*(1+data bits+parity bits)+stop ticks apart.
- R5: When the shifter is idle, the queue holds a byte and break is off, the start bit begins at the clock edge that samples the next tick pulse.
- R6: With fifoEn 1, the queue holds 16 bytes and a write to a full queue is dropped.
- R7: With fifoEn 0, only one byte can wait and further writes are dropped. Any change of fifoEn empties the queue within one clock.
- R8: While breakEn is 1, the line is 0, no new character starts and waiting bytes stay queued. They are sent after breakEn returns to 0.
- R9: With loopEn 1, serOut stays 1 and loopOut carries the serial stream. With loopEn 0, loopOut stays 1.
- R10: shifterEmpty is 0 from the start bit until the stop period ends. fifoEmpty is 1 exactly when no byte waits, so it reads 1 during the only byte's frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One pulse per sixteenth of a bit time |
| wrEn | input | 1 | Write strobe for wrData |
| wrData | input | 8 | Byte to queue |
| fifoEn | input | 1 | 1: 16-entry queue, 0: single holding register |
| charLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Adds a parity bit |
| parityOdd | input | 1 | Selects odd parity when 1, even parity when 0 |
| stopLong | input | 1 | Selects the long stop period |
| breakEn | input | 1 | Forces the line low and holds the queue |
| loopEn | input | 1 | Sends the stream to loopOut and holds serOut high |
| serOut | output | 1 | Serial line |
| loopOut | output | 1 | Diagnostic copy of the stream |
| fifoEmpty | output | 1 | No byte waiting |
| shifterEmpty | output | 1 | No character in progress |

## Verification
The assertions assume three things about the inputs. tick is a one-cycle pulse. The format inputs change only while shifterEmpty is 1. fifoEn changes only when a flush is intended. The bench drives tick from a free-running divider and changes the format only after both status flags read idle. It also halts the tick divider while it loads bytes, so that queue depth, dropped writes and break holding can be observed before any byte leaves.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  typedef struct packed {
    logic load;
    logic shift;
  } txStrobes_t;
endpackage

// File: rtl/txq_datapath.sv
module txq_datapath
  import txq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fifoEn,
  input  logic [1:0]        charLen,
  input  logic              parityOdd,
  input  txStrobes_t        strobes,
  output logic              dataBit,
  output logic              parityBit,
  output logic              fifoEmpty,
  output logic [CNT_W-1:0]  fifoCount
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [DATA_W-1:0] shiftReg, mask;
  logic [CNT_W-1:0] capacity;
  logic fifoEnQ, flush, accept, pop;

  assign flush = fifoEn != fifoEnQ;
  assign capacity = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign accept = wrEn && (fifoCount < capacity);
  assign pop = strobes.load && (fifoCount != '0);
  assign fifoEmpty = fifoCount == '0;
  assign dataBit = shiftReg[0];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask[i] = i < (int'(charLen) + 5);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fifoCount <= '0;
      fifoEnQ <= 1'b0;
    end else begin
      fifoEnQ <= fifoEn;
      if (flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        fifoCount <= '0;
      end else begin
        if (accept) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
        if (pop) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
        fifoCount <= fifoCount + CNT_W'(accept) - CNT_W'(pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parityBit <= 1'b0;
    end else if (pop) begin
      shiftReg <= mem[rdPtr];
      parityBit <= (^(mem[rdPtr] & mask)) ^ parityOdd;
    end else if (strobes.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end
endmodule

// File: rtl/txq_control.sv
module txq_control
  import txq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICKS_PER_BIT = 16,
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1),
  localparam int BITCNT_W = $clog2(DATA_W)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       fifoEmpty,
  input  logic       breakEn,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       stopLong,
  input  logic       dataBit,
  input  logic       parityBit,
  output txStrobes_t strobes,
  output logic       lineBit,
  output logic       shifterEmpty
);
  txState_t state;
  logic [CNT_W-1:0] tickCnt, stopTicks, bitLimit;
  logic [BITCNT_W-1:0] bitCnt, lastBit;
  logic bitEnd, canStart;

  assign lastBit = BITCNT_W'(charLen) + BITCNT_W'(4);
  assign shifterEmpty = state == ST_IDLE;

  always_comb begin
    if (!stopLong) stopTicks = CNT_W'(TICKS_PER_BIT);
    else if (charLen == 2'd0) stopTicks = CNT_W'(TICKS_PER_BIT * 3 / 2);
    else stopTicks = CNT_W'(2 * TICKS_PER_BIT);
    bitLimit = (state == ST_STOP) ? stopTicks - CNT_W'(1) : CNT_W'(TICKS_PER_BIT - 1);
    bitEnd = tick && (state != ST_IDLE) && (tickCnt == bitLimit);
    canStart = tick && !fifoEmpty && !breakEn;
    strobes.load = canStart && ((state == ST_IDLE) || ((state == ST_STOP) && bitEnd));
    strobes.shift = bitEnd && ((state == ST_START) ||
                               ((state == ST_DATA) && (bitCnt != lastBit)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tickCnt <= '0;
      bitCnt <= '0;
      lineBit <= 1'b1;
    end else if (strobes.load) begin
      state <= ST_START;
      tickCnt <= '0;
      lineBit <= 1'b0;
    end else if (bitEnd) begin
      tickCnt <= '0;
      case (state)
        ST_START: begin
          state <= ST_DATA;
          bitCnt <= '0;
          lineBit <= dataBit;
        end
        ST_DATA: begin
          if (bitCnt == lastBit) begin
            state <= parityEn ? ST_PARITY : ST_STOP;
            lineBit <= parityEn ? parityBit : 1'b1;
          end else begin
            bitCnt <= bitCnt + BITCNT_W'(1);
            lineBit <= dataBit;
          end
        end
        ST_PARITY: begin
          state <= ST_STOP;
          lineBit <= 1'b1;
        end
        default: begin
          state <= ST_IDLE;
          lineBit <= 1'b1;
        end
      endcase
    end else if (tick && (state != ST_IDLE)) begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/serial_tx_queue.sv
module serial_tx_queue
  import txq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH = 16,
  parameter int TICKS_PER_BIT = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fifoEn,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              stopLong,
  input  logic              breakEn,
  input  logic              loopEn,
  output logic              serOut,
  output logic              loopOut,
  output logic              fifoEmpty,
  output logic              shifterEmpty
);
  txStrobes_t strobes;
  logic dataBit, parityBit, lineBit, lineOut;
  logic [CNT_W-1:0] fifoCount;

  txq_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .fifoEn(fifoEn),
    .charLen(charLen), .parityOdd(parityOdd), .strobes(strobes),
    .dataBit(dataBit), .parityBit(parityBit), .fifoEmpty(fifoEmpty),
    .fifoCount(fifoCount)
  );

  txq_control #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_control (
    .clk(clk), .rstN(rstN), .tick(tick), .fifoEmpty(fifoEmpty), .breakEn(breakEn),
    .charLen(charLen), .parityEn(parityEn), .stopLong(stopLong),
    .dataBit(dataBit), .parityBit(parityBit), .strobes(strobes),
    .lineBit(lineBit), .shifterEmpty(shifterEmpty)
  );

  assign lineOut = lineBit & ~breakEn;
  assign serOut = loopEn ? 1'b1 : lineOut;
  assign loopOut = loopEn ? lineOut : 1'b1;
endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             fifoEn,
  input logic             breakEn,
  input logic             loopEn,
  input logic             serOut,
  input logic             loopOut,
  input logic             shifterEmpty,
  input logic             load,
  input logic [CNT_W-1:0] count
);
  // R9
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) loopEn |-> serOut);
  // R9
  loop_idle_chk: assert property (@(posedge clk) disable iff (!rstN) !loopEn |-> loopOut);
  // R8
  break_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (breakEn && !loopEn) |-> !serOut);
  // R8
  break_hold_chk: assert property (@(posedge clk) disable iff (!rstN) breakEn |-> !load);
  // R5
  load_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN) load |-> tick);
  // R5
  start_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!shifterEmpty && $past(shifterEmpty)) |-> $past(tick));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN) count <= CNT_W'(DEPTH));
  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH) && !load && $stable(fifoEn)) |=> (count == CNT_W'(DEPTH)));
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shifterEmpty && !breakEn && !loopEn) |-> serOut);
endmodule

bind serial_tx_queue txq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .fifoEn(fifoEn), .breakEn(breakEn),
  .loopEn(loopEn), .serOut(serOut), .loopOut(loopOut), .shifterEmpty(shifterEmpty),
  .load(strobes.load), .count(fifoCount)
);

// File: tb/test_serial_tx_queue.sv
module test_serial_tx_queue;
  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic fifoEn = 1'b1, parityEn = 1'b0, parityOdd = 1'b0, stopLong = 1'b0;
  logic breakEn = 1'b0, loopEn = 1'b0;
  logic [1:0] charLen = 2'd3;
  logic serOut, loopOut, fifoEmpty, shifterEmpty;
  logic tickRun = 1'b0;
  logic [1:0] div = '0;
  longint tickNum = 0;
  int checks = 0, errors = 0;

  serial_tx_queue i_serial_tx_queue (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrData(wrData), .fifoEn(fifoEn),
    .charLen(charLen), .parityEn(parityEn), .parityOdd(parityOdd), .stopLong(stopLong),
    .breakEn(breakEn), .loopEn(loopEn), .serOut(serOut), .loopOut(loopOut),
    .fifoEmpty(fifoEmpty), .shifterEmpty(shifterEmpty)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    div <= div + 2'd1;
    tick <= tickRun && (div == 2'd3);
  end

  always @(posedge clk) if (tick) tickNum <= tickNum + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic lineNow(input bit viaLoop);
    return viaLoop ? loopOut : serOut;
  endfunction

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTicks(input int n);
    longint tgt;
    tgt = tickNum + n;
    while (tickNum < tgt) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (!shifterEmpty || !fifoEmpty) @(negedge clk);
  endtask

  // counts serOut low samples over n ticks; expects none
  task automatic watchIdle(input int n, input string req);
    longint tgt;
    int lows;
    lows = 0;
    tgt = tickNum + n;
    while (tickNum < tgt) begin
      @(negedge clk);
      if (serOut !== 1'b1) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  task automatic expectFrame(input logic [7:0] d, input int nb, input bit pe, input bit po,
                             input bit viaLoop, output longint st);
    logic prev, cur, exp;
    logic [7:0] m;
    longint tgt;
    int total;
    string req;
    m = 8'hFF >> (8 - nb);
    prev = lineNow(viaLoop);
    forever begin
      @(negedge clk);
      cur = lineNow(viaLoop);
      if (prev && !cur) break;
      prev = cur;
    end
    st = tickNum;
    total = 2 + nb + (pe ? 1 : 0);
    for (int k = 0; k < total; k++) begin
      tgt = st + 16 * k + 8;
      while (tickNum < tgt) @(negedge clk);
      if (k == 0) begin exp = 1'b0; req = "R2"; end
      else if (k <= nb) begin exp = d[k-1]; req = "R2"; end
      else if (pe && k == nb + 1) begin exp = (^(d & m)) ^ po; req = "R3"; end
      else begin exp = 1'b1; req = "R4"; end
      check(lineNow(viaLoop) === exp, req, lineNow(viaLoop), exp);
      if (k == 0) check(shifterEmpty === 1'b0, "R10 busy", shifterEmpty, 0);
      if (viaLoop) check(serOut === 1'b1, "R9 serOut parked", serOut, 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint st, prevSt, gap;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(serOut === 1'b1, "R1 serOut", serOut, 1);
    check(fifoEmpty === 1'b1, "R1 fifoEmpty", fifoEmpty, 1);
    check(shifterEmpty === 1'b1, "R1 shifterEmpty", shifterEmpty, 1);

    // R2 R3 R4 R5: sweep of all formats, three back-to-back bytes each
    for (int cl = 0; cl < 4; cl++)
      for (int pm = 0; pm < 3; pm++)
        for (int sl = 0; sl < 2; sl++) begin
          waitIdle();
          charLen = 2'(cl);
          parityEn = pm != 0;
          parityOdd = pm == 2;
          stopLong = sl[0];
          tickRun = 1'b0;
          for (int j = 0; j < 3; j++) wr(8'(37 * (cl * 6 + pm * 2 + sl) + 11 * j + 5));
          tickRun = 1'b1;
          prevSt = 0;
          for (int j = 0; j < 3; j++) begin
            d = 8'(37 * (cl * 6 + pm * 2 + sl) + 11 * j + 5);
            expectFrame(d, cl + 5, pm != 0, pm == 2, 1'b0, st);
            if (j > 0) begin
              gap = 16 * (1 + cl + 5 + (pm != 0 ? 1 : 0)) +
                    (sl == 0 ? 16 : (cl == 0 ? 24 : 32));
              check(st - prevSt == gap, "R4 spacing", st - prevSt, gap);
            end
            prevSt = st;
          end
        end

    // R6 depth 16, 17th write dropped
    waitIdle();
    charLen = 2'd3; parityEn = 1'b0; stopLong = 1'b0;
    tickRun = 1'b0;
    for (int i = 0; i < 17; i++) wr(8'(i * 13 + 1));
    check(fifoEmpty === 1'b0, "R10 fifoEmpty", fifoEmpty, 0);
    tickRun = 1'b1;
    for (int i = 0; i < 16; i++) expectFrame(8'(i * 13 + 1), 8, 1'b0, 1'b0, 1'b0, st);
    check(fifoEmpty === 1'b1, "R10 fifoEmpty after last pop", fifoEmpty, 1);
    watchIdle(300, "R6 dropped write");
    check(shifterEmpty === 1'b1, "R10 shifterEmpty", shifterEmpty, 1);

    // R7 mode change flushes queue
    tickRun = 1'b0;
    for (int i = 0; i < 3; i++) wr(8'hA0 + 8'(i));
    check(fifoEmpty === 1'b0, "R7 before flush", fifoEmpty, 0);
    fifoEn = 1'b0;
    @(negedge clk);
    check(fifoEmpty === 1'b1, "R7 flush", fifoEmpty, 1);
    // R7 single holding register
    wr(8'h5A);
    wr(8'h00);
    check(fifoEmpty === 1'b0, "R7 holding", fifoEmpty, 0);
    tickRun = 1'b1;
    expectFrame(8'h5A, 8, 1'b0, 1'b0, 1'b0, st);
    watchIdle(300, "R7 second write dropped");
    fifoEn = 1'b1;
    @(negedge clk);

    // R8 break holds line low and keeps queue
    tickRun = 1'b0;
    wr(8'h3C);
    wr(8'hC3);
    breakEn = 1'b1;
    #1 check(serOut === 1'b0, "R8 break low", serOut, 0);
    tickRun = 1'b1;
    begin
      longint tgt;
      int highs, starts;
      highs = 0; starts = 0;
      tgt = tickNum + 200;
      while (tickNum < tgt) begin
        @(negedge clk);
        if (serOut !== 1'b0) highs++;
        if (shifterEmpty !== 1'b1) starts++;
      end
      check(highs == 0, "R8 line held low", highs, 0);
      check(starts == 0, "R8 no start", starts, 0);
    end
    check(fifoEmpty === 1'b0, "R8 queue kept", fifoEmpty, 0);
    breakEn = 1'b0;
    expectFrame(8'h3C, 8, 1'b0, 1'b0, 1'b0, st);
    expectFrame(8'hC3, 8, 1'b0, 1'b0, 1'b0, st);

    // R9 loopback
    waitIdle();
    check(loopOut === 1'b1, "R9 loopOut idle", loopOut, 1);
    loopEn = 1'b1;
    charLen = 2'd1; parityEn = 1'b1; parityOdd = 1'b1; stopLong = 1'b1;
    tickRun = 1'b0;
    wr(8'h2D);
    tickRun = 1'b1;
    expectFrame(8'h2D, 6, 1'b1, 1'b1, 1'b1, st);
    waitIdle();
    loopEn = 1'b0;
    waitTicks(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule